// File: doc/BRIEF.md
# Isochronous Audio Packet Cadence Generator

This block sets the pace of an outgoing audio stream on an isochronous bus with 125 µs cycles of 3072 ticks each. On every advance strobe, which arrives once per bus cycle, it produces one descriptor: how many data blocks (audio frames) the next packet carries, and the sub-cycle tick offset at which the packet's timestamped sample falls. When no timestamped sample falls within the cycle, the offset is the no-information code 0xFFFF.

Integer-ratio rates (32, 48, 96 and 192 kHz) use a fixed count and a fixed offset step. The 44.1 kHz family (44.1, 88.2 and 176.4 kHz) needs fractional cadences. The block produces these exactly with small phase counters and no divider: 5/6 or 11/12 or 22/23 frames per cycle, and offset steps of 1386 or 1387 ticks. In blocking mode each packet carries either a full SYT interval of frames or nothing. In non-blocking mode the count follows the rate cadence.

Software or a sequencer selects the rate and mode and pulses the initialise strobe. It then pulses the advance strobe once per bus cycle and reads the descriptor on the cycle where valid is high.

Top module: `iso_cadence_gen`

## Requirements
- R1: After reset, valid is 0, syt_offset is 0xFFFF and data_blocks is 0. The internal state equals the 48 kHz initial state, so the first advance before any initialise yields offset 0 and 6 blocks.
- R2: Valid is high for exactly the one clock after a clock in which adv was high and init was low. On every clock without such an advance, data_blocks and syt_offset keep their values.
- R3: A last-offset register starts at 3072. On each advance, if it is below 3072 the new value is last plus the increment, otherwise last minus 3072. The new value is stored. If it is 3072 or more, the output is 0xFFFF; otherwise the output is the value itself.
- R4: Rate codes are 0=32k, 1=44.1k, 2=48k, 3=88.2k, 4=96k, 5=176.4k, 6=192k. In non-blocking mode the integer rates give a constant count of 4, 6, 12 or 24 blocks and an offset increment of 3072 (32k) or 1024 (others).
- R5: At 44.1k in non-blocking mode the count is 5 + (p[0] XOR (p==0 OR p>=40)), for a phase p that starts at 0 and wraps at 80. This gives 6,6,5,6,5,… and 441 blocks over 80 advances.
- R6: At 88.2k and 176.4k the count is 11·k + (p==0), where k is code>>1. The phase wraps at 40 or 20, so each full round carries 441 blocks.
- R7: For the 44.1k family the increment is 1386 plus 1 when (q mod 13) is nonzero and a multiple of 4, or when q is 146. The offset phase q starts at 67, steps only when last is below 3072, and wraps at 147. The first offsets are therefore 0, 1386, 2772, 0xFFFF, 1087.
- R8: In blocking mode the count is 0 when the offset is 0xFFFF and syt_ivl otherwise.
- R9: init reloads the initial state for the presented rate, takes priority over a simultaneous adv, and leaves valid low on the next clock.
- R10: The count phase advances only on non-blocking advances. Advances in blocking mode leave the non-blocking cadence where it was.
- R11: Rate code 7 behaves as 48 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_sel | input | 3 | Sample-rate code, sampled on init and used on every advance |
| blocking | input | 1 | 1 selects blocking mode |
| syt_ivl | input | DB_W | Frames per packet in blocking mode |
| init | input | 1 | Reload initial state for rate_sel |
| adv | input | 1 | One pulse per bus cycle: emit next descriptor |
| data_blocks | output | DB_W | Data blocks in the packet |
| syt_offset | output | 16 | Tick offset in cycle, or 0xFFFF for no information |
| valid | output | 1 | Descriptor produced on the previous clock |

## Verification
On every cycle the assertions check the valid pulse and output hold rules, the legal range of the offset (below 3072 or 0xFFFF), and empty blocking packets on no-information cycles. They also check the bounds of the phase counters and the subtract-3072 step of the last-offset register. Only the bench scenarios can show the exact 44.1k-family sequences: the 6,6,5,… and 12,11,… patterns, the 1386/1387 offset cadence, and 441-block totals per round. The bench scenarios also cover phase retention across blocking advances and initialise priority.

// File: rtl/cad_pkg.sv
`timescale 1ns/1ps
package cad_pkg;
  localparam int TICKS_PER_CYCLE = 3072;
  localparam int FRAC_INC        = 1386;
  localparam int FRAC_WRAP       = 147;
  localparam int FRAC_START      = 67;
  localparam int FRAC_START_M13  = FRAC_START % 13;
  localparam int OFS_W           = 16;
  localparam logic [OFS_W-1:0] NO_INFO = 16'hFFFF;

  typedef enum logic [2:0] {
    RATE_32K, RATE_44K1, RATE_48K, RATE_88K2,
    RATE_96K, RATE_176K4, RATE_192K, RATE_RSVD
  } rate_e;

  function automatic logic is_frac(input logic [2:0] code);
    return code[0] && (code != 3'd7);
  endfunction
endpackage

// File: rtl/cad_rst_sync.sv
`timescale 1ns/1ps
module cad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cad_block_count.sv
`timescale 1ns/1ps
module cad_block_count
  import cad_pkg::*;
#(
  parameter int DB_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            adv,
  input  logic [2:0]      rate,
  input  logic            blocking,
  input  logic [DB_W-1:0] syt_ivl,
  input  logic            no_info,
  output logic [DB_W-1:0] count
);
  localparam int PH_W = 7;

  // Shared state: constant count for integer rates, phase for fractional ones
  logic [PH_W-1:0] state_q, state_n;
  logic [1:0]      k;
  logic [PH_W-1:0] wrap;
  logic            frac;
  int              cnt_i;

  assign frac = is_frac(rate);
  assign k    = rate[2:1];
  assign wrap = PH_W'(7'd80 >> k);

  function automatic logic [PH_W-1:0] init_val(input logic [2:0] r);
    case (r)
      3'd0:    return PH_W'(4);
      3'd2:    return PH_W'(6);
      3'd4:    return PH_W'(12);
      3'd6:    return PH_W'(24);
      3'd7:    return PH_W'(6);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    cnt_i = 0;
    if (blocking) begin
      cnt_i = no_info ? 0 : int'(syt_ivl);
    end else if (frac) begin
      if (k == 2'd0)
        cnt_i = 5 + int'(state_q[0] ^ ((state_q == '0) || (state_q >= PH_W'(40))));
      else
        cnt_i = 11 * int'(k) + int'(state_q == '0);
    end else begin
      cnt_i = int'(state_q);
    end
    count = DB_W'(cnt_i);
  end

  always_comb begin
    state_n = state_q;
    if (init)
      state_n = init_val(rate);
    else if (adv && !blocking && frac)
      state_n = (PH_W'(state_q + 7'd1) >= wrap) ? '0 : PH_W'(state_q + 7'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_W'(6);
    else        state_q <= state_n;
  end

  a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state_q < PH_W'(80));

  a_r10_blocking_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && blocking && !init) |=> $stable(state_q));
endmodule

// File: rtl/cad_syt_offset.sv
`timescale 1ns/1ps
module cad_syt_offset
  import cad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic [2:0]       rate,
  output logic [OFS_W-1:0] ofs,
  output logic             no_info
);
  localparam int LAST_W = $clog2(2 * TICKS_PER_CYCLE);
  localparam int ST_W   = $clog2(TICKS_PER_CYCLE + 1);
  localparam logic [LAST_W-1:0] TK = LAST_W'(TICKS_PER_CYCLE);

  logic [LAST_W-1:0] last_q, last_n, new_ofs;
  logic [ST_W-1:0]   st_q, st_n, inc;
  logic [3:0]        m13_q, m13_n;
  logic              frac, below, final_ph;

  assign frac     = is_frac(rate);
  assign below    = last_q < TK;
  assign final_ph = st_q == ST_W'(FRAC_WRAP - 1);

  always_comb begin
    if (frac)
      inc = ST_W'(FRAC_INC) +
            ST_W'(((m13_q != 4'd0) && (m13_q[1:0] == 2'b00)) || final_ph);
    else
      inc = st_q;
    new_ofs = below ? LAST_W'(last_q + LAST_W'(inc)) : LAST_W'(last_q - TK);
    no_info = new_ofs >= TK;
    ofs     = no_info ? NO_INFO : OFS_W'(new_ofs);
  end

  always_comb begin
    last_n = last_q;
    st_n   = st_q;
    m13_n  = m13_q;
    if (init) begin
      last_n = TK;
      if (frac) begin
        st_n  = ST_W'(FRAC_START);
        m13_n = 4'(FRAC_START_M13);
      end else begin
        st_n  = (rate == 3'd0) ? ST_W'(TICKS_PER_CYCLE) : ST_W'(TICKS_PER_CYCLE / 3);
        m13_n = 4'd0;
      end
    end else if (adv) begin
      last_n = new_ofs;
      if (below && frac) begin
        st_n  = final_ph ? '0 : ST_W'(st_q + 1'b1);
        m13_n = (final_ph || m13_q == 4'd12) ? 4'd0 : 4'(m13_q + 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= TK;
      st_q   <= ST_W'(TICKS_PER_CYCLE / 3);
      m13_q  <= 4'd0;
    end else begin
      last_q <= last_n;
      st_q   <= st_n;
      m13_q  <= m13_n;
    end
  end

  a_r3_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !init && !below) |=> (last_q == $past(last_q) - TK));

  a_r3_last_bound: assert property (@(posedge clk) disable iff (!rst_n)
    last_q < LAST_W'(2 * TICKS_PER_CYCLE));

  a_r7_mod13_bound: assert property (@(posedge clk) disable iff (!rst_n)
    m13_q < 4'd13);
endmodule

// File: rtl/iso_cadence_gen.sv
`timescale 1ns/1ps
module iso_cadence_gen
  import cad_pkg::*;
#(
  parameter int DB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rate_sel,
  input  logic             blocking,
  input  logic [DB_W-1:0]  syt_ivl,
  input  logic             init,
  input  logic             adv,
  output logic [DB_W-1:0]  data_blocks,
  output logic [OFS_W-1:0] syt_offset,
  output logic             valid
);
  logic             rst_sync_n;
  logic [OFS_W-1:0] ofs_c;
  logic             no_info_c;
  logic [DB_W-1:0]  cnt_c;
  logic [DB_W-1:0]  db_q, db_n;
  logic [OFS_W-1:0] ofs_q, ofs_n;
  logic             vld_q, vld_n;

  cad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cad_syt_offset u_ofs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .init    (init),
    .adv     (adv),
    .rate    (rate_sel),
    .ofs     (ofs_c),
    .no_info (no_info_c)
  );

  cad_block_count #(.DB_W(DB_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .init     (init),
    .adv      (adv),
    .rate     (rate_sel),
    .blocking (blocking),
    .syt_ivl  (syt_ivl),
    .no_info  (no_info_c),
    .count    (cnt_c)
  );

  always_comb begin
    db_n  = db_q;
    ofs_n = ofs_q;
    vld_n = 1'b0;
    if (adv && !init) begin
      db_n  = cnt_c;
      ofs_n = ofs_c;
      vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      db_q  <= '0;
      ofs_q <= NO_INFO;
      vld_q <= 1'b0;
    end else begin
      db_q  <= db_n;
      ofs_q <= ofs_n;
      vld_q <= vld_n;
    end
  end

  assign data_blocks = db_q;
  assign syt_offset  = ofs_q;
  assign valid       = vld_q;

  a_r2_valid_after_adv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid |-> $past(adv && !init));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(adv && !init) |=> ($stable(data_blocks) && $stable(syt_offset)));

  a_r3_offset_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid |-> ((syt_offset < OFS_W'(TICKS_PER_CYCLE)) || (syt_offset == NO_INFO)));

  a_r8_blocking_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid && $past(blocking) && syt_offset == NO_INFO) |-> (data_blocks == '0));

  a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    init |=> !valid);
endmodule

// File: tb/sim_iso_cadence_gen.sv
`timescale 1ns/1ps
module sim_iso_cadence_gen;
  localparam int DB_W = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [2:0]      rate_sel;
  logic            blocking;
  logic [DB_W-1:0] syt_ivl;
  logic            init;
  logic            adv;
  logic [DB_W-1:0] data_blocks;
  logic [15:0]     syt_offset;
  logic            valid;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  int m_ds, m_os, m_last;
  int obs_db, obs_ofs;

  always #2 clk = ~clk;

  iso_cadence_gen #(.DB_W(DB_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .blocking(blocking),
    .syt_ivl(syt_ivl), .init(init), .adv(adv),
    .data_blocks(data_blocks), .syt_offset(syt_offset), .valid(valid)
  );

  function automatic bit frac_rate(input int r);
    return (r == 1) || (r == 3) || (r == 5);
  endfunction

  function automatic int ivl_for(input int r);
    if (r == 3 || r == 4) return 16;
    if (r == 5 || r == 6) return 32;
    return 8;
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_init(input int r);
    m_last = 3072;
    case (r)
      0: begin m_ds = 4;  m_os = 3072; end
      1, 3, 5: begin m_ds = 0; m_os = 67; end
      4: begin m_ds = 12; m_os = 1024; end
      6: begin m_ds = 24; m_os = 1024; end
      default: begin m_ds = 6; m_os = 1024; end
    endcase
  endtask

  task automatic model_step(output int edb, output int eofs);
    int r, inc, off, idx, wrapv;
    r = int'(rate_sel);
    if (m_last < 3072) begin
      if (frac_rate(r)) begin
        idx = m_os % 13;
        inc = 1386 + (((idx != 0 && idx % 4 == 0) || m_os == 146) ? 1 : 0);
        m_os = (m_os + 1) % 147;
      end else inc = m_os;
      off = m_last + inc;
    end else off = m_last - 3072;
    m_last = off;
    eofs = (off >= 3072) ? 16'hFFFF : off;
    if (blocking) edb = (eofs == 16'hFFFF) ? 0 : int'(syt_ivl);
    else if (frac_rate(r)) begin
      if (r == 1) begin
        edb = 5 + ((m_ds % 2 == 1) != (m_ds == 0 || m_ds >= 40) ? 1 : 0);
        wrapv = 80;
      end else if (r == 3) begin
        edb = 11 + (m_ds == 0 ? 1 : 0); wrapv = 40;
      end else begin
        edb = 22 + (m_ds == 0 ? 1 : 0); wrapv = 20;
      end
      m_ds = (m_ds + 1 == wrapv) ? 0 : m_ds + 1;
    end else edb = m_ds;
  endtask

  task automatic do_cycle(input bit a, input bit i, input string tag);
    int edb, eofs;
    bit ev;
    int pdb, pofs;
    pdb = obs_db; pofs = obs_ofs;
    edb = 0; eofs = 0;
    adv = a; init = i;
    if (i) begin model_init(int'(rate_sel)); ev = 0; end
    else if (a) begin model_step(edb, eofs); ev = 1; end
    else ev = 0;
    @(negedge clk);
    check_eq(tag, "valid", int'(valid), int'(ev));
    if (ev) begin
      check_eq(tag, "data_blocks", int'(data_blocks), edb);
      check_eq(tag, "syt_offset", int'(syt_offset), eofs);
    end else begin
      check_eq("R2", "held data_blocks", int'(data_blocks), pdb);
      check_eq("R2", "held syt_offset", int'(syt_offset), pofs);
    end
    obs_db = int'(data_blocks);
    obs_ofs = int'(syt_offset);
    adv = 0; init = 0;
  endtask

  task automatic start_rate(input int r, input bit blk);
    rate_sel = 3'(r);
    blocking = blk;
    syt_ivl = DB_W'(ivl_for(r));
    do_cycle(0, 1, "R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sum;
    int first_db [5];
    int first_of [5];
    void'($urandom(32'd2718));
    rst_n = 0; adv = 0; init = 0; rate_sel = 3'd2; blocking = 0; syt_ivl = 8;
    model_init(2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset values
    check_eq("R1", "valid", int'(valid), 0);
    check_eq("R1", "syt_offset", int'(syt_offset), 16'hFFFF);
    check_eq("R1", "data_blocks", int'(data_blocks), 0);
    obs_db = 0; obs_ofs = 16'hFFFF;
    // R1: state equals 48 kHz initial state
    do_cycle(1, 0, "R1");
    check_eq("R1", "first db", obs_db, 6);
    check_eq("R1", "first ofs", obs_ofs, 0);
    repeat (6) do_cycle(1, 0, "R4");

    // R5 / R7: 44.1k pattern and offsets
    start_rate(1, 0);
    sum = 0;
    for (int n = 0; n < 80; n++) begin
      do_cycle(1, 0, "R5");
      sum += obs_db;
      if (n < 5) begin first_db[n] = obs_db; first_of[n] = obs_ofs; end
    end
    check_eq("R5", "sum over 80", sum, 441);
    check_eq("R5", "db0", first_db[0], 6);
    check_eq("R5", "db1", first_db[1], 6);
    check_eq("R5", "db2", first_db[2], 5);
    check_eq("R5", "db3", first_db[3], 6);
    check_eq("R5", "db4", first_db[4], 5);
    check_eq("R7", "ofs0", first_of[0], 0);
    check_eq("R7", "ofs1", first_of[1], 1386);
    check_eq("R7", "ofs2", first_of[2], 2772);
    check_eq("R7", "ofs3", first_of[3], 16'hFFFF);
    check_eq("R7", "ofs4", first_of[4], 1087);
    repeat (300) do_cycle(1, 0, "R7");

    // R6: 88.2k and 176.4k rounds
    start_rate(3, 0);
    sum = 0;
    for (int n = 0; n < 40; n++) begin do_cycle(1, 0, "R6"); sum += obs_db; end
    check_eq("R6", "88.2k sum over 40", sum, 441);
    start_rate(5, 0);
    sum = 0;
    for (int n = 0; n < 20; n++) begin do_cycle(1, 0, "R6"); sum += obs_db; end
    check_eq("R6", "176.4k sum over 20", sum, 441);

    // R4: integer rates
    for (int r = 0; r < 7; r += 2) begin
      start_rate(r, 0);
      repeat (12) do_cycle(1, 0, "R4");
    end

    // R8: blocking mode
    start_rate(2, 1);
    repeat (16) do_cycle(1, 0, "R8");
    start_rate(1, 1);
    repeat (40) do_cycle(1, 0, "R8");

    // R10: blocking advances keep non-blocking phase
    start_rate(1, 0);
    repeat (3) do_cycle(1, 0, "R10");
    blocking = 1;
    repeat (7) do_cycle(1, 0, "R10");
    blocking = 0;
    repeat (10) do_cycle(1, 0, "R10");

    // R11: reserved code behaves as 48k
    start_rate(7, 0);
    repeat (8) do_cycle(1, 0, "R11");

    // R9: init with simultaneous advance
    rate_sel = 3'd4; syt_ivl = 16; blocking = 0;
    do_cycle(1, 1, "R9");
    do_cycle(1, 0, "R9");
    check_eq("R9", "db after init", obs_db, 12);
    check_eq("R9", "ofs after init", obs_ofs, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int p;
      p = int'($urandom_range(0, 99));
      if (p < 3) begin
        rate_sel = 3'($urandom_range(0, 7));
        syt_ivl = DB_W'(ivl_for(int'(rate_sel)));
        blocking = 1'($urandom_range(0, 1));
        do_cycle(1'($urandom_range(0, 1)), 1, "R9");
      end else if (p < 5) begin
        blocking = ~blocking;
        do_cycle(1, 0, "R10");
      end else if (p < 75) begin
        do_cycle(1, 0, "R3");
      end else begin
        do_cycle(0, 0, "R2");
      end
    end
    finish_run();
  end
endmodule